// File: doc/BRIEF.md
# Multi-Port Behavioural SRAM

This block is a synthesizable behavioural memory with two independently clocked ports. The first is a read-only port. The second is a combined port that either reads or writes in a given cycle. Word width, depth and write-mask granularity are parameters. The combined port can be built with or without a segment write mask.

A read registers two things at the port's clock edge: an enable flag, updated every cycle, and the address, updated only when the read is enabled. The output then combinationally shows the array word at the held address. It therefore follows any later write to that word until a new address is captured.

An optional scramble mode makes a port drive pseudo-random data whenever its registered enable flag is low. Simulation can then expose logic that consumes read data on cycles without a read.

Top module: `mpsram_model`

## Requirements
- R1: After reset, both ports hold address 0 and have their registered read-enable flags clear. The output of either port then shows word 0 without any read being issued.
- R2: When a port's read enable is high at its clock edge, that port captures the address. From then on its data output equals the array word at that address.
- R3: While a port's read enable is low, its held address stays the same. Its output keeps tracking the word at that address, including a write to it made at the same edge the address was captured.
- R4: The combined port captures a read address only when `rw_en` is high and `rw_wmode` is low. A write cycle leaves its held address and output word selection unchanged.
- R5: The array is written only at an `rw_clk` edge where both `rw_en` and `rw_wmode` are high. If either one is low, nothing is written.
- R6: With masking built in, a write updates segment i, bits [i*GRAN +: GRAN], only when `rw_wmask[i]` is 1. Other segments keep their old value. The segment count is WIDTH/GRAN, and GRAN defaults to WIDTH.
- R7: Without masking built in, `rw_wmask` is ignored and every write stores the whole word.
- R8: With scramble mode on, a port whose registered enable flag is low drives pseudo-random data that changes from cycle to cycle. With the flag high, the port drives the array word. With scramble mode off, the port always drives the array word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Read port clock |
| rd_rst_n | input | 1 | Read port asynchronous active-low reset |
| rd_en | input | 1 | Read port enable |
| rd_addr | input | AW = max(clog2(DEPTH),1) | Read port address |
| rd_data | output | WIDTH | Read port data |
| rw_clk | input | 1 | Combined port clock |
| rw_rst_n | input | 1 | Combined port asynchronous active-low reset |
| rw_en | input | 1 | Combined port enable |
| rw_wmode | input | 1 | 1 = write, 0 = read |
| rw_addr | input | AW | Combined port address |
| rw_wmask | input | WIDTH/GRAN | Segment write mask, bit i covers bits [i*GRAN +: GRAN] |
| rw_wdata | input | WIDTH | Write data |
| rw_rdata | output | WIDTH | Combined port read data |

## Verification
The write-landing and write-idle assertions assume that the combined port is the only writer of the array. They also assume addresses stay below DEPTH, so that every indexed word exists. The held-address assertions assume each port's reset is asserted before its first clock edge. The bench keeps to these assumptions by using power-of-two depths and random addresses drawn modulo the depth. It drives both port clocks from one source, holds both resets from time zero, and exercises the no-write cycles with only the combined port's enable or write mode toggled.

// File: rtl/sram_pkg.sv
package sram_pkg;

  // Address bits for a given depth, never below one.
  function automatic int addr_bits(input int depth);
    int b;
    b = $clog2(depth);
    return (b < 1) ? 1 : b;
  endfunction

  // Number of 32-bit scramble words needed to cover a width.
  function automatic int scramble_reps(input int width);
    return (width + 31) / 32;
  endfunction

endpackage

// File: rtl/sram_read_port.sv
module sram_read_port #(
  parameter int WIDTH   = 32,
  parameter int AW      = 6,
  parameter bit GARBAGE = 1'b0,
  parameter logic [31:0] SEED = 32'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] word,
  output logic [AW-1:0]    addr_q,
  output logic [WIDTH-1:0] data
);

  logic          flag_q;
  logic          flag_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    flag_d = en;
    addr_d = addr_q;
    if (en) begin
      addr_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else begin
      flag_q <= flag_d;
      addr_q <= addr_d;
    end
  end

  generate
    if (GARBAGE) begin : g_scramble
      localparam int REP = sram_pkg::scramble_reps(WIDTH);
      logic [31:0]       lfsr_q;
      logic [31:0]       lfsr_d;
      logic [31:0]       t0;
      logic [31:0]       t1;
      logic [REP*32-1:0] wide;

      always_comb begin
        t0     = lfsr_q ^ (lfsr_q << 13);
        t1     = t0 ^ (t0 >> 17);
        lfsr_d = t1 ^ (t1 << 5);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lfsr_q <= SEED;
        end else begin
          lfsr_q <= lfsr_d;
        end
      end

      assign wide = {REP{lfsr_q}};
      assign data = flag_q ? word : wide[WIDTH-1:0];
    end else begin : g_plain
      logic unused_flag;
      assign unused_flag = flag_q;
      assign data = word;
    end
  endgenerate

  AST_FLAG_TRACKS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> flag_q); // R2
  AST_ADDR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (addr_q == $past(addr))); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(addr_q)); // R3

endmodule

// File: rtl/sram_mask_merge.sv
module sram_mask_merge #(
  parameter int WIDTH  = 32,
  parameter int GRAN   = 32,
  parameter bit MASKED = 1'b1,
  localparam int SEG   = WIDTH / GRAN
) (
  input  logic [WIDTH-1:0] old_word,
  input  logic [WIDTH-1:0] new_data,
  input  logic [SEG-1:0]   mask,
  output logic [WIDTH-1:0] merged
);

  logic [SEG-1:0] take;

  generate
    if (MASKED) begin : g_mask_used
      assign take = mask;
    end else begin : g_mask_ignored
      logic unused_mask;
      assign unused_mask = ^mask;
      assign take = '1;
    end

    for (genvar i = 0; i < SEG; i++) begin : g_seg
      assign merged[i*GRAN +: GRAN] = take[i] ? new_data[i*GRAN +: GRAN]
                                              : old_word[i*GRAN +: GRAN];
    end
  endgenerate

endmodule

// File: rtl/mpsram_model.sv
module mpsram_model #(
  parameter int WIDTH     = 32,
  parameter int DEPTH     = 64,
  parameter int GRAN      = WIDTH,
  parameter bit RW_MASKED = 1'b1,
  parameter bit GARBAGE   = 1'b0,
  localparam int AW       = sram_pkg::addr_bits(DEPTH),
  localparam int SEG      = WIDTH / GRAN
) (
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rw_clk,
  input  logic             rw_rst_n,
  input  logic             rw_en,
  input  logic             rw_wmode,
  input  logic [AW-1:0]    rw_addr,
  input  logic [SEG-1:0]   rw_wmask,
  input  logic [WIDTH-1:0] rw_wdata,
  output logic [WIDTH-1:0] rw_rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  logic [AW-1:0]    rd_addr_q;
  logic [AW-1:0]    rw_addr_q;
  logic             rw_rd_en;
  logic             rw_fire;
  logic [WIDTH-1:0] old_word;
  logic [WIDTH-1:0] merged;

  assign rw_rd_en = rw_en & ~rw_wmode;
  assign rw_fire  = rw_en & rw_wmode;
  assign old_word = mem[rw_addr];

  sram_read_port #(
    .WIDTH(WIDTH), .AW(AW), .GARBAGE(GARBAGE), .SEED(32'h2545_F491)
  ) i_rd_port (
    .clk(rd_clk), .rst_n(rd_rst_n), .en(rd_en), .addr(rd_addr),
    .word(mem[rd_addr_q]), .addr_q(rd_addr_q), .data(rd_data)
  );

  sram_read_port #(
    .WIDTH(WIDTH), .AW(AW), .GARBAGE(GARBAGE), .SEED(32'h9E37_79B9)
  ) i_rw_port (
    .clk(rw_clk), .rst_n(rw_rst_n), .en(rw_rd_en), .addr(rw_addr),
    .word(mem[rw_addr_q]), .addr_q(rw_addr_q), .data(rw_rdata)
  );

  sram_mask_merge #(
    .WIDTH(WIDTH), .GRAN(GRAN), .MASKED(RW_MASKED)
  ) i_merge (
    .old_word(old_word), .new_data(rw_wdata), .mask(rw_wmask), .merged(merged)
  );

  always_ff @(posedge rw_clk) begin
    if (rw_fire) begin
      mem[rw_addr] <= merged;
    end
  end

  AST_WRITE_NO_CAPTURE: assert property (@(posedge rw_clk) disable iff (!rw_rst_n)
    (rw_en && rw_wmode) |=> $stable(rw_addr_q)); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge rw_clk) disable iff (!rw_rst_n)
    !rw_fire |=> (mem[$past(rw_addr)] == $past(old_word))); // R5

  generate
    for (genvar i = 0; i < SEG; i++) begin : g_seg_chk
      AST_SEG_WRITTEN: assert property (@(posedge rw_clk) disable iff (!rw_rst_n)
        (rw_fire && (!RW_MASKED || rw_wmask[i])) |=>
          (mem[$past(rw_addr)][i*GRAN +: GRAN] == $past(rw_wdata[i*GRAN +: GRAN]))); // R6
      AST_SEG_KEPT: assert property (@(posedge rw_clk) disable iff (!rw_rst_n)
        (rw_fire && RW_MASKED && !rw_wmask[i]) |=>
          (mem[$past(rw_addr)][i*GRAN +: GRAN] == $past(old_word[i*GRAN +: GRAN]))); // R6
    end
  endgenerate

endmodule

// File: tb/test_mpsram_model.sv
module test_mpsram_model;

  logic clk;
  logic rst_n;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  // Instance A: 32-bit words, 64 deep, 8-bit mask segments, scramble off
  logic        a_rd_en, a_rw_en, a_rw_wmode;
  logic [5:0]  a_rd_addr, a_rw_addr;
  logic [3:0]  a_rw_wmask;
  logic [31:0] a_rw_wdata, a_rd_data, a_rw_rdata;
  logic [31:0] model_a [64];
  int          a_rd_held, a_rw_held;

  // Instance B: 16-bit words, 16 deep, unmasked, scramble on
  logic        b_rd_en, b_rw_en, b_rw_wmode;
  logic [3:0]  b_rd_addr, b_rw_addr;
  logic [0:0]  b_rw_wmask;
  logic [15:0] b_rw_wdata, b_rd_data, b_rw_rdata;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  mpsram_model #(.WIDTH(32), .DEPTH(64), .GRAN(8), .RW_MASKED(1'b1), .GARBAGE(1'b0)) i_mpsram_model (
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(a_rd_en), .rd_addr(a_rd_addr), .rd_data(a_rd_data),
    .rw_clk(clk), .rw_rst_n(rst_n), .rw_en(a_rw_en), .rw_wmode(a_rw_wmode), .rw_addr(a_rw_addr),
    .rw_wmask(a_rw_wmask), .rw_wdata(a_rw_wdata), .rw_rdata(a_rw_rdata)
  );

  mpsram_model #(.WIDTH(16), .DEPTH(16), .RW_MASKED(1'b0), .GARBAGE(1'b1)) i_mpsram_model_b (
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(b_rd_en), .rd_addr(b_rd_addr), .rd_data(b_rd_data),
    .rw_clk(clk), .rw_rst_n(rst_n), .rw_en(b_rw_en), .rw_wmode(b_rw_wmode), .rw_addr(b_rw_addr),
    .rw_wmask(b_rw_wmask), .rw_wdata(b_rw_wdata), .rw_rdata(b_rw_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge_a(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] m);
    logic [31:0] r;
    r = old;
    for (int s = 0; s < 4; s++) if (m[s]) r[s*8 +: 8] = d[s*8 +: 8];
    return r;
  endfunction

  // Write on A's combined port; returns at the negedge after the write edge.
  task automatic a_write(input int ad, input logic [31:0] d, input logic [3:0] m);
    a_rw_en = 1'b1; a_rw_wmode = 1'b1; a_rw_addr = 6'(ad); a_rw_wmask = m; a_rw_wdata = d;
    @(negedge clk);
    model_a[ad] = merge_a(model_a[ad], d, m);
    a_rw_en = 1'b0; a_rw_wmode = 1'b0;
  endtask

  task automatic a_rd_read(input int ad);
    a_rd_en = 1'b1; a_rd_addr = 6'(ad);
    @(negedge clk);
    a_rd_en = 1'b0; a_rd_held = ad;
    chk("R2 read port data", a_rd_data, model_a[ad]);
  endtask

  task automatic a_rw_read(input int ad);
    a_rw_en = 1'b1; a_rw_wmode = 1'b0; a_rw_addr = 6'(ad);
    @(negedge clk);
    a_rw_en = 1'b0; a_rw_held = ad;
    chk("R4 combined port read", a_rw_rdata, model_a[ad]);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] prev;
    int diffs, changes;
    r = $urandom(32'd4711);
    rst_n = 1'b0;
    a_rd_en = 0; a_rw_en = 0; a_rw_wmode = 0; a_rd_addr = 0; a_rw_addr = 0;
    a_rw_wmask = 0; a_rw_wdata = 0;
    b_rd_en = 0; b_rw_en = 0; b_rw_wmode = 0; b_rd_addr = 0; b_rw_addr = 0;
    b_rw_wmask = 0; b_rw_wdata = 0;
    for (int i = 0; i < 64; i++) model_a[i] = 32'h0;
    a_rd_held = 0; a_rw_held = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Fill A so every word is known
    for (int i = 0; i < 64; i++) a_write(i, 32'hA500_0000 | 32'(i), 4'hF);

    // R1: with no read issued, both ports still point at word 0
    chk("R1 read port shows word 0 after reset", a_rd_data, model_a[0]);
    chk("R1 combined port shows word 0 after reset", a_rw_rdata, model_a[0]);

    // R3: write to held address 0 is visible without a new read
    a_write(0, 32'h1357_9BDF, 4'hF);
    chk("R3 held address tracks write", a_rd_data, 32'h1357_9BDF);

    // R6: partial masks
    a_write(7, 32'hFFFF_FFFF, 4'b0101);
    a_rd_read(7);
    chk("R6 mask 0101 segments", a_rd_data, 32'hA5FF_00FF);
    a_write(7, 32'h1122_3344, 4'b0000);
    chk("R6 empty mask keeps word", a_rd_data, 32'hA5FF_00FF);

    // R5: enable low with write mode, and write mode low with enable, both no write
    a_rw_en = 1'b0; a_rw_wmode = 1'b1; a_rw_addr = 6'd7; a_rw_wmask = 4'hF; a_rw_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    a_rw_wmode = 1'b0;
    chk("R5 no write with enable low", a_rd_data, 32'hA5FF_00FF);
    a_rw_en = 1'b1;
    @(negedge clk);
    a_rw_en = 1'b0; a_rw_held = 7;
    chk("R5 no write in read mode", a_rd_data, 32'hA5FF_00FF);

    // R4: write on combined port does not move its held address
    a_rw_read(5);
    a_write(9, 32'h0BAD_F00D, 4'hF);
    chk("R4 write keeps combined held address", a_rw_rdata, model_a[5]);

    // R3: same-edge capture and write
    a_rd_en = 1'b1; a_rd_addr = 6'd12;
    a_write(12, 32'h600D_CAFE, 4'b1100);
    a_rd_en = 1'b0; a_rd_held = 12;
    chk("R3 same-edge write visible", a_rd_data, model_a[12]);

    // Constrained random mix on A
    for (int it = 0; it < 400; it++) begin
      int op, ad;
      op = int'($urandom % 4);
      ad = int'($urandom % 64);
      case (op)
        0: a_write(ad, $urandom, 4'($urandom));
        1: a_rd_read(ad);
        2: a_rw_read(ad);
        default: begin
          a_rd_en = 1'b1; a_rd_addr = 6'(ad);
          a_write(ad, $urandom, 4'($urandom));
          a_rd_en = 1'b0; a_rd_held = ad;
          chk("R3 random same-edge", a_rd_data, model_a[ad]);
        end
      endcase
      chk("R3 read port hold", a_rd_data, model_a[a_rd_held]);
      chk("R8 scramble off follows array", a_rw_rdata, model_a[a_rw_held]);
    end

    // Instance B: R7 mask ignored
    b_rw_en = 1'b1; b_rw_wmode = 1'b1; b_rw_addr = 4'd3; b_rw_wmask = 1'b0; b_rw_wdata = 16'h1234;
    @(negedge clk);
    b_rw_en = 1'b0; b_rw_wmode = 1'b0;
    b_rd_en = 1'b1; b_rd_addr = 4'd3;
    @(negedge clk);
    b_rd_en = 1'b0;
    chk("R7 unmasked write stores word", 32'(b_rd_data), 32'h1234);
    chk("R8 flag high drives array", 32'(b_rd_data), 32'h1234);

    // R8: flag low gives changing pseudo-random data
    diffs = 0; changes = 0; prev = b_rd_data;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (b_rd_data !== 16'h1234) diffs++;
      if (b_rd_data !== prev) changes++;
      prev = b_rd_data;
    end
    chk("R8 scramble differs from array", 32'(diffs >= 6), 32'd1);
    chk("R8 scramble changes per cycle", 32'(changes >= 6), 32'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule